// File: doc/BRIEF.md
# Multi-channel compare match timer

A bank of five independent 32-bit up-counters. Each counter has its own compare value and its own control/status word, and one shared run register starts and stops them. A counter advances by one on every clock cycle in which its tick input is high and its run bit is set. When the count equals the compare value on such a cycle, the channel clears the count to zero and raises a match flag. A channel in one-shot mode then halts and drops its own run bit. A channel in free-running mode keeps counting up from zero.

If the compare value is all ones, the same match also raises an overflow flag. This lets software detect a full wrap of the counter. Each channel drives an interrupt line, which is its match flag gated by an enable bit.

Software reaches the bank through a word-addressed register port. Configuration is written while a channel is stopped. While a channel runs, the only write that has an effect on its control/status word is clearing a flag, using a read-then-write-zero sequence.

Top module: `match_timer_bank`

## Requirements
- R1: After reset, all run bits are 0, every counter reads 0, every compare value reads 0xFFFFFFFF, every control/status word reads 0, and every interrupt output is 0.
- R2: A channel whose run bit is 1 adds one to its counter on each cycle in which its tick bit is 1 and the count differs from the compare value. A channel whose run bit is 0 never changes its count, and channels do not affect one another.
- R3: The run register is at word address 0, with bit n controlling channel n. Writing 0 to a bit stops that channel, and its count keeps its value; writing 1 again resumes counting from that value.
- R4: In one-shot mode (mode bit 0), a ticked cycle whose count equals the compare value clears the count to 0 and sets the match flag. It also clears the channel's run bit, and no further counting takes place. This clearing of the run bit wins over a run-register write in the same cycle.
- R5: In free-running mode (mode bit 1), a ticked cycle whose count equals the compare value clears the count to 0 and sets the match flag. The run bit stays 1, so the following ticks count on from 0.
- R6: The overflow flag is set by a match only when the compare value is 0xFFFFFFFF. A match against any other compare value leaves it unchanged.
- R7: While a channel's run bit is 1, writes to its counter, its compare value, and the mode and enable bits of its control/status word are ignored.
- R8: A flag is cleared only by writing 0 to its bit after a read of the control/status word that returned it as 1. Writing 0 without that read leaves the flag set, and writing 1 never sets a flag.
- R9: If a match sets a flag in the same cycle as a valid clear write to that flag, the flag stays set.
- R10: Interrupt output n is 1 exactly when channel n's match flag and its interrupt-enable bit are both 1.
- R11: Channel n's registers sit at word addresses 1+3n (control/status), 2+3n (counter) and 3+3n (compare). The control/status bits are: bit 0 match flag, bit 1 overflow flag, bit 2 mode, bit 3 interrupt enable. Other addresses and bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 5 | Per-channel count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used to arm flag clearing) |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| irq | output | 5 | Per-channel interrupt request |

## Verification
A flag that a match is setting and a software write that clears it can land on the same clock edge, and the set must win. To provoke this, the bench runs a channel in free-running mode with a compare value of 0 and its tick held high, so the channel matches on every cycle. The bench then reads the control/status word and writes the clear while the ticks continue. The flag is judged by reading it back after the ticks stop: it must still be 1, and a second read-and-clear with no tick running must bring it to 0.

// File: rtl/match_timer_bank.sv
module match_timer_bank #(
  parameter int NCH = 5,
  parameter int W   = 32,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tick,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   rdata,
  output logic [NCH-1:0] irq
);
  localparam int B_MF = 0;
  localparam int B_OV = 1;
  localparam int B_MD = 2;
  localparam int B_IE = 3;

  logic [NCH-1:0] run, hw_stop, mf, ov, mode, ie;
  logic [W-1:0]   cnt [NCH];
  logic [W-1:0]   cmp [NCH];

  wire wr_run = wr_en && (addr == '0);

  always_ff @(posedge clk)
    if (!rst_n) run <= '0;
    else        run <= (wr_run ? wdata[NCH-1:0] : run) & ~hw_stop;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [AW-1:0] A_CS  = AW'(1 + 3*ch);
    localparam logic [AW-1:0] A_CNT = AW'(2 + 3*ch);
    localparam logic [AW-1:0] A_CMP = AW'(3 + 3*ch);

    logic [W-1:0] cnt_q, cmp_q;
    logic mf_q, ov_q, md_q, ie_q, mf_arm, ov_arm;

    wire w_cs  = wr_en && addr == A_CS;
    wire w_cnt = wr_en && addr == A_CNT && !run[ch];
    wire w_cmp = wr_en && addr == A_CMP && !run[ch];
    wire r_cs  = rd_en && addr == A_CS;
    wire step  = run[ch] && tick[ch];
    wire hit   = step && cnt_q == cmp_q;

    assign hw_stop[ch] = hit && !md_q;

    always_ff @(posedge clk)
      if (!rst_n)     cnt_q <= '0;
      else if (w_cnt) cnt_q <= wdata;
      else if (step)  cnt_q <= hit ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk)
      if (!rst_n)     cmp_q <= '1;
      else if (w_cmp) cmp_q <= wdata;

    always_ff @(posedge clk)
      if (!rst_n) begin
        md_q <= 1'b0;
        ie_q <= 1'b0;
      end else if (w_cs && !run[ch]) begin
        md_q <= wdata[B_MD];
        ie_q <= wdata[B_IE];
      end

    always_ff @(posedge clk)
      if (!rst_n)                              mf_q <= 1'b0;
      else if (hit)                            mf_q <= 1'b1;
      else if (w_cs && !wdata[B_MF] && mf_arm) mf_q <= 1'b0;

    always_ff @(posedge clk)
      if (!rst_n)                              ov_q <= 1'b0;
      else if (hit && &cmp_q)                  ov_q <= 1'b1;
      else if (w_cs && !wdata[B_OV] && ov_arm) ov_q <= 1'b0;

    always_ff @(posedge clk)
      if (!rst_n) begin
        mf_arm <= 1'b0;
        ov_arm <= 1'b0;
      end else if (r_cs) begin
        mf_arm <= mf_q;
        ov_arm <= ov_q;
      end else if (w_cs) begin
        mf_arm <= 1'b0;
        ov_arm <= 1'b0;
      end

    assign cnt[ch]  = cnt_q;
    assign cmp[ch]  = cmp_q;
    assign mf[ch]   = mf_q;
    assign ov[ch]   = ov_q;
    assign mode[ch] = md_q;
    assign ie[ch]   = ie_q;
  end

  assign irq = mf & ie;

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata[NCH-1:0] = run;
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(1 + 3*c)) begin
        rdata[B_MF] = mf[c];
        rdata[B_OV] = ov[c];
        rdata[B_MD] = mode[c];
        rdata[B_IE] = ie[c];
      end
      if (addr == AW'(2 + 3*c)) rdata = cnt[c];
      if (addr == AW'(3 + 3*c)) rdata = cmp[c];
    end
  end
endmodule

// File: rtl/match_timer_bank_chk.sv
module match_timer_bank_chk #(
  parameter int NCH = 5,
  parameter int W   = 32,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] tick,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [W-1:0]   wdata,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] mf,
  input logic [NCH-1:0] ov,
  input logic [NCH-1:0] mode,
  input logic [NCH-1:0] ie,
  input logic [W-1:0]   cnt [NCH],
  input logic [W-1:0]   cmp [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    wire hit    = run[c] && tick[c] && cnt[c] == cmp[c];
    wire wr_cs  = wr_en && addr == AW'(1 + 3*c);
    wire wr_cnt = wr_en && addr == AW'(2 + 3*c);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] && tick[c] && cnt[c] != cmp[c] |=> cnt[c] == $past(cnt[c]) + 1'b1); // R2
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] && !wr_cnt |=> $stable(cnt[c])); // R3
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !mode[c] |=> !run[c] && cnt[c] == '0 && mf[c]); // R4
    AST_FREE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      hit && mode[c] |=> run[c] && cnt[c] == '0 && mf[c]); // R5
    AST_OVF_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov[c]) |-> &$past(cmp[c])); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] |=> $stable(cmp[c]) && $stable(mode[c]) && $stable(ie[c])); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hit && wr_cs && !wdata[0] |=> mf[c]); // R9
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !(mf[c] && ie[c]) |-> !irq[c]); // R10
  end
endmodule

bind match_timer_bank match_timer_bank_chk #(.NCH(NCH), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .run(run), .mf(mf), .ov(ov), .mode(mode),
  .ie(ie), .cnt(cnt), .cmp(cmp)
);

// File: tb/test_match_timer_bank.sv
module test_match_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  irq;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  match_timer_bank i_match_timer_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic int a_cs(int c);  return 1 + 3*c; endfunction
  function automatic int a_cnt(int c); return 2 + 3*c; endfunction
  function automatic int a_cmp(int c); return 3 + 3*c; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = 5'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = 5'(a); rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(int n, logic [4:0] mask);
    if (n > 0) begin
      tick = mask;
      repeat (n) @(negedge clk);
      tick = '0;
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int nb, ec, ef, er;
    logic ieb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, d);        chk("R1 run", d, 0);
    rd(a_cs(0), d);  chk("R1 ctrl", d, 0);
    rd(a_cnt(4), d); chk("R1 cnt", d, 0);
    rd(a_cmp(2), d); chk("R1 cmp", d, 32'hFFFF_FFFF);
    chk("R1 irq", 32'(irq), 0);
    rd(31, d);       chk("R11 unmapped", d, 0);

    for (int c = 0; c < 5; c++)
      for (int m = 0; m < 2; m++)
        for (int n = 0; n < 4; n++)
          for (int t = 0; t <= 2*n + 2; t++) begin
            nb = (c + 1) % 5;
            ieb = n[0];
            wr(0, 0);
            rd(a_cs(c), d);
            wr(a_cs(c), {28'd0, ieb, m[0], 2'b00});
            wr(a_cnt(c), 0);
            wr(a_cnt(nb), 0);
            wr(a_cmp(c), n);
            wr(0, 32'(1 << c));
            ticks(t, 5'h1F);
            ec = m ? t % (n + 1) : (t <= n ? t : 0);
            ef = (t > n) ? 1 : 0;
            er = (m == 1 || t <= n) ? 1 : 0;
            rd(a_cnt(c), d);
            chk((t <= n) ? "R2 count" : (m ? "R5 count" : "R4 count"), d, ec);
            rd(a_cs(c), d);
            chk(m ? "R5 flag" : "R4 flag", 32'(d[0]), ef);
            chk("R6 no ovf", 32'(d[1]), 0);
            chk("R11 mode bit", 32'(d[2]), m);
            rd(0, d);
            chk(m ? "R5 run" : "R4 run", 32'(d[c]), er);
            chk("R10 irq", 32'(irq[c]), ef & ieb);
            rd(a_cnt(nb), d);
            chk("R2 independent", d, 0);
          end
    wr(0, 0);

    wr(a_cs(0), 0); wr(a_cnt(0), 0); wr(a_cmp(0), 0);
    wr(0, 1); ticks(1, 5'h01);
    wr(a_cs(0), 0);
    rd(a_cs(0), d); chk("R8 no read no clear", 32'(d[0]), 1);
    wr(a_cs(0), 0);
    rd(a_cs(0), d); chk("R8 read then clear", 32'(d[0]), 0);
    wr(a_cs(0), 1);
    rd(a_cs(0), d); chk("R8 write one", 32'(d[0]), 0);

    wr(a_cs(1), 32'hC); wr(a_cnt(1), 0); wr(a_cmp(1), 0);
    wr(0, 2);
    tick = 5'h02;
    repeat (3) @(negedge clk);
    rd(a_cs(1), d);
    wr(a_cs(1), 0);
    tick = '0;
    rd(a_cs(1), d);
    chk("R9 set wins", 32'(d[0]), 1);
    chk("R7 mode kept", 32'(d[2]), 1);
    chk("R7 ie kept", 32'(d[3]), 1);
    wr(a_cs(1), 32'hC);
    rd(a_cs(1), d); chk("R8 clear idle", 32'(d[0]), 0);
    wr(0, 0);

    wr(a_cs(2), 32'h4); wr(a_cnt(2), 0); wr(a_cmp(2), 10);
    wr(0, 4);
    wr(a_cmp(2), 3); wr(a_cnt(2), 7);
    wr(0, 0);
    rd(a_cmp(2), d); chk("R7 cmp frozen", d, 10);
    rd(a_cnt(2), d); chk("R7 cnt frozen", d, 0);

    wr(a_cs(3), 32'h4); wr(a_cnt(3), 0); wr(a_cmp(3), 100);
    wr(0, 8); ticks(6, 5'h08);
    wr(0, 0); ticks(4, 5'h08);
    rd(a_cnt(3), d); chk("R3 stop holds", d, 6);
    wr(0, 8); ticks(2, 5'h08);
    rd(a_cnt(3), d); chk("R3 resume", d, 8);
    wr(0, 0);

    wr(a_cs(4), 0); wr(a_cnt(4), 32'hFFFF_FFFE); wr(a_cmp(4), 32'hFFFF_FFFF);
    wr(0, 16); ticks(1, 5'h10);
    rd(a_cnt(4), d); chk("R6 at top", d, 32'hFFFF_FFFF);
    rd(a_cs(4), d);  chk("R6 no ovf yet", 32'(d[1]), 0);
    ticks(1, 5'h10);
    rd(a_cnt(4), d); chk("R6 wrapped", d, 0);
    rd(a_cs(4), d);
    chk("R6 ovf set", 32'(d[1]), 1);
    chk("R4 match", 32'(d[0]), 1);
    rd(0, d); chk("R4 halted", 32'(d[4]), 0);

    finish_run();
  end
endmodule